// File: doc/BRIEF.md
# Decimal Quotient Digit Assembler with Half-Even Rounding

This block sits at the back end of a radix-10 digit-recurrence divider. The recurrence delivers one signed quotient digit per cycle, each in the range −9..+9. The block folds these digits into an ordinary BCD quotient as they arrive, so no carry-propagating conversion is needed once the recurrence ends. It does this by keeping two running registers. One holds the quotient so far. The other holds that same value minus one unit in its last place. For each digit, the next contents of both registers come from one of the two by a shift plus one appended digit.

The divider produces one digit more than the target precision P. That extra digit serves only as the guard digit for rounding. After the last digit, the divider presents the final partial remainder as two flags, negative and zero, together with a finish strobe. In that finishing cycle the block does the following:
- It picks the truncated quotient. A negative remainder means the true value lies below the running quotient, so the minus-one register is used.
- It rounds to P digits, to nearest with ties to even. A zero remainder is what separates a true tie from a value just above the halfway point.
- It reports whether the rounded coefficient is exact.

The coefficient is not normalised afterwards. Handling of the exponent and packing of the result belong to other blocks.

Top module: `dec_otf_round`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid`, `res_carry` and `res_exact` are 0 and `res_coef` is all zeros.
- R2: A digit is a 5-bit two's-complement value from −9 to +9, taken when `dig_valid` is 1. Exactly P+1 digits form one quotient, and the first digit is the most significant. The truncated value is the weighted sum of the digits, with weight 10 for each later position.
- R3: A `start` pulse discards all digits received before it, so a restarted quotient depends only on the digits that follow.
- R4: When `fin_valid` carries `rem_neg`=1 and `rem_zero`=0, the truncated (P+1)-digit value is the digit sum minus one before rounding.
- R5: The rounded coefficient is the upper P digits of the truncated value. One is added when the guard digit (the last digit) is above 5. Nothing is added when it is below 5.
- R6: With guard digit 5 and `rem_zero`=1, one is added only if the upper P digits are odd, so the result is even.
- R7: With guard digit 5 and `rem_zero`=0, one is always added.
- R8: When `rem_zero`=1, `rem_neg` has no effect on the result.
- R9: Rounding up from P nines gives `res_coef` all zeros with `res_carry`=1. Otherwise `res_carry` is 0.
- R10: `res_exact` is 1 exactly when `rem_zero`=1 and the guard digit is 0.
- R11: `res_valid` is high for exactly the one cycle after `fin_valid`. `res_coef`, `res_carry` and `res_exact` hold until the next `fin_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new quotient; takes priority over a digit in the same cycle |
| dig_valid | input | 1 | Quotient digit present |
| dig | input | 5 | Signed quotient digit, two's complement, −9..+9 |
| fin_valid | input | 1 | Finish strobe after the last digit |
| rem_neg | input | 1 | Final remainder is negative |
| rem_zero | input | 1 | Final remainder is zero |
| res_valid | output | 1 | Result strobe, one cycle |
| res_coef | output | 4*P | Rounded BCD coefficient; digit k at bits 4k+3..4k, least significant at 3..0 |
| res_carry | output | 1 | Round-up overflowed out of P digits |
| res_exact | output | 1 | Rounded coefficient equals the exact quotient |

## Verification
The bench aims at the digit sequences that exercise the minus-one register: negative digits, zeros after negative digits, and a final −3 that borrows through six zeros. A design that appended digits without switching register sources would lose those borrows and return a value that is far too large. Three separate stimuli probe the guard-digit-5 cases: a zero remainder with an even upper part, a zero remainder with an odd upper part, and a nonzero remainder. A design that rounded half-up, or that ignored the remainder's sign or zero flag, would miss by one unit in exactly one of these. The bench also drives all nines up to the carry-out, restarts a quotient partway through, and asserts a negative sign together with a zero remainder, which must leave the result untouched.

// File: rtl/dotf_pkg.sv
package dotf_pkg;
  // signed quotient digit, two's complement, legal range -9..+9
  typedef logic signed [4:0] sdig_t;

  localparam sdig_t DIG_MAX = 5'sd9;
  localparam sdig_t DIG_MIN = -5'sd9;

  // source picked for a running register on each digit
  typedef enum logic {SRC_Q = 1'b0, SRC_QM = 1'b1} src_t;
endpackage

// File: rtl/dotf_append.sv
// Next values of the running quotient and quotient-minus-one registers.
module dotf_append
  import dotf_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic [4*NDIG-1:0] q_cur,
  input  logic [4*NDIG-1:0] qm_cur,
  input  sdig_t             dig,
  output logic [4*NDIG-1:0] q_nxt,
  output logic [4*NDIG-1:0] qm_nxt
);
  localparam int W = 4 * NDIG;

  src_t       q_src;
  src_t       qm_src;
  sdig_t      dq_s;
  sdig_t      dqm_s;
  logic [W-1:0] q_base;
  logic [W-1:0] qm_base;

  always_comb begin
    if (dig > 5'sd0) begin
      q_src  = SRC_Q;
      qm_src = SRC_Q;
      dq_s   = dig;
      dqm_s  = dig - 5'sd1;
    end else if (dig == 5'sd0) begin
      q_src  = SRC_Q;
      qm_src = SRC_QM;
      dq_s   = 5'sd0;
      dqm_s  = 5'sd9;
    end else begin
      q_src  = SRC_QM;
      qm_src = SRC_QM;
      dq_s   = dig + 5'sd10;
      dqm_s  = dig + 5'sd9;
    end
  end

  assign q_base  = (q_src == SRC_QM) ? qm_cur : q_cur;
  assign qm_base = (qm_src == SRC_QM) ? qm_cur : q_cur;

  // shift one decade up (top digit drops, arithmetic is modulo 10^NDIG)
  assign q_nxt  = {q_base[W-5:0], dq_s[3:0]};
  assign qm_nxt = {qm_base[W-5:0], dqm_s[3:0]};
endmodule

// File: rtl/dotf_bcd_inc.sv
// Ripple BCD incrementer over NDIG digits.
module dotf_bcd_inc #(
  parameter int NDIG = 7
) (
  input  logic [4*NDIG-1:0] val,
  input  logic              inc,
  output logic [4*NDIG-1:0] sum,
  output logic              carry
);
  logic [NDIG:0] cy;

  assign cy[0] = inc;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] a;
    logic       is9;
    assign a   = val[4*i +: 4];
    assign is9 = (a == 4'd9);
    assign sum[4*i +: 4] = cy[i] ? (is9 ? 4'd0 : a + 4'd1) : a;
    assign cy[i+1]       = cy[i] & is9;
  end

  assign carry = cy[NDIG];
endmodule

// File: rtl/dotf_rne.sv
// Final selection, half-even rounding and exactness.
module dotf_rne #(
  parameter int P = 7
) (
  input  logic [4*(P+1)-1:0] q_cur,
  input  logic [4*(P+1)-1:0] qm_cur,
  input  logic               rem_neg,
  input  logic               rem_zero,
  output logic [4*P-1:0]     coef,
  output logic               carry,
  output logic               exact
);
  localparam int W = 4 * (P + 1);

  logic [W-1:0]   trunc;
  logic [3:0]     guard;
  logic [4*P-1:0] upper;
  logic           sticky;
  logic           round_up;

  // a negative remainder means the true value lies below the running quotient
  assign trunc  = (rem_neg && !rem_zero) ? qm_cur : q_cur;
  assign guard  = trunc[3:0];
  assign upper  = trunc[W-1:4];
  assign sticky = !rem_zero;

  always_comb begin
    if (guard > 4'd5)      round_up = 1'b1;
    else if (guard < 4'd5) round_up = 1'b0;
    else                   round_up = sticky | upper[0];
  end

  dotf_bcd_inc #(.NDIG(P)) i_inc (
    .val   (upper),
    .inc   (round_up),
    .sum   (coef),
    .carry (carry)
  );

  assign exact = rem_zero && (guard == 4'd0);
endmodule

// File: rtl/dec_otf_round.sv
module dec_otf_round
  import dotf_pkg::*;
#(
  parameter int P = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dig_valid,
  input  logic [4:0]     dig,
  input  logic           fin_valid,
  input  logic           rem_neg,
  input  logic           rem_zero,
  output logic           res_valid,
  output logic [4*P-1:0] res_coef,
  output logic           res_carry,
  output logic           res_exact
);
  localparam int NDIG = P + 1;
  localparam int W    = 4 * NDIG;
  localparam int CW   = $clog2(NDIG + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(NDIG);

  logic [W-1:0]   q_r, q_n, qm_r, qm_n;
  logic [W-1:0]   q_app, qm_app;
  logic [CW-1:0]  cnt_r, cnt_n;
  logic           vld_r, vld_n;
  logic [4*P-1:0] coef_r, coef_n, coef_c;
  logic           carry_r, carry_n, carry_c;
  logic           exact_r, exact_n, exact_c;
  sdig_t          dig_s;

  assign dig_s = sdig_t'(dig);

  dotf_append #(.NDIG(NDIG)) i_append (
    .q_cur  (q_r),
    .qm_cur (qm_r),
    .dig    (dig_s),
    .q_nxt  (q_app),
    .qm_nxt (qm_app)
  );

  dotf_rne #(.P(P)) i_rne (
    .q_cur    (q_r),
    .qm_cur   (qm_r),
    .rem_neg  (rem_neg),
    .rem_zero (rem_zero),
    .coef     (coef_c),
    .carry    (carry_c),
    .exact    (exact_c)
  );

  // next-state
  always_comb begin
    q_n     = q_r;
    qm_n    = qm_r;
    cnt_n   = cnt_r;
    coef_n  = coef_r;
    carry_n = carry_r;
    exact_n = exact_r;
    vld_n   = fin_valid;
    if (start) begin
      q_n   = '0;
      qm_n  = {NDIG{4'd9}};   // zero minus one, modulo 10^NDIG
      cnt_n = '0;
    end else if (dig_valid) begin
      q_n  = q_app;
      qm_n = qm_app;
      if (cnt_r != CNT_FULL) cnt_n = cnt_r + CW'(1);
    end
    if (fin_valid) begin
      coef_n  = coef_c;
      carry_n = carry_c;
      exact_n = exact_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r     <= '0;
      qm_r    <= {NDIG{4'd9}};
      cnt_r   <= '0;
      vld_r   <= 1'b0;
      coef_r  <= '0;
      carry_r <= 1'b0;
      exact_r <= 1'b0;
    end else begin
      q_r     <= q_n;
      qm_r    <= qm_n;
      cnt_r   <= cnt_n;
      vld_r   <= vld_n;
      coef_r  <= coef_n;
      carry_r <= carry_n;
      exact_r <= exact_n;
    end
  end

  assign res_valid = vld_r;
  assign res_coef  = coef_r;
  assign res_carry = carry_r;
  assign res_exact = exact_r;

  // R2: only legal signed digits enter the recurrence registers
  assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (dig_s >= DIG_MIN && dig_s <= DIG_MAX));

  // R2: finishing happens only after exactly P+1 digits
  assert_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |-> (cnt_r == CNT_FULL));

  // R3: a start pulse empties the digit counter
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_r == '0));

  // R11: result strobe follows the finish strobe by one cycle
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |=> res_valid);

  assert_valid_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_valid |=> !res_valid);

  // R11: outputs hold between finishes
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_valid |=> ($stable(res_coef) && $stable(res_carry) && $stable(res_exact)));

  // R10: a nonzero remainder never yields an exact result
  assert_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && !rem_zero) |=> !res_exact);
endmodule

// File: tb/test_dec_otf_round.sv
`timescale 1ns/1ps
module test_dec_otf_round;
  localparam int P = 7;
  localparam int N = P + 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start, dig_valid, fin_valid, rem_neg, rem_zero;
  logic [4:0]     dig;
  logic           res_valid, res_carry, res_exact;
  logic [4*P-1:0] res_coef;

  int checks = 0;
  int failures = 0;
  int dq[N];

  always #2 clk = ~clk;   // 250 MHz

  dec_otf_round #(.P(P)) i_dec_otf_round (
    .clk(clk), .rst_n(rst_n), .start(start), .dig_valid(dig_valid), .dig(dig),
    .fin_valid(fin_valid), .rem_neg(rem_neg), .rem_zero(rem_zero),
    .res_valid(res_valid), .res_coef(res_coef), .res_carry(res_carry),
    .res_exact(res_exact)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4*P-1:0] to_bcd(input longint v);
    logic [4*P-1:0] r = '0;
    longint x = v;
    for (int k = 0; k < P; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic send_digits(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      dig_valid = 1'b1;
      dig = 5'(dq[i]);
      @(negedge clk);
    end
    dig_valid = 1'b0;
    dig = '0;
  endtask

  // drive one full quotient and compare against an independent integer model
  task automatic run_case(input string req, input bit neg, input bit zero);
    longint v = 0, t, u, r, pw = 1;
    int g;
    bit up, ex_carry, ex_exact;
    logic [4*P-1:0] held;
    for (int k = 0; k < P; k++) pw = pw * 10;
    for (int i = 0; i < N; i++) v = v * 10 + longint'(dq[i]);
    t = (neg && !zero) ? v - 1 : v;
    g = int'(t % 10);
    u = t / 10;
    if (g > 5) up = 1'b1;
    else if (g < 5) up = 1'b0;
    else up = !zero || (u % 2 == 1);
    r = u + (up ? 1 : 0);
    ex_carry = (r == pw);
    r = r % pw;
    ex_exact = zero && (g == 0);

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    send_digits(N);
    fin_valid = 1'b1; rem_neg = neg; rem_zero = zero;
    @(negedge clk);
    fin_valid = 1'b0; rem_neg = 1'b0; rem_zero = 1'b0;
    chk({req, " R11 valid"}, longint'(res_valid), 1);
    chk({req, " coef"}, longint'(res_coef), longint'(to_bcd(r)));
    chk({req, " R9 carry"}, longint'(res_carry), longint'(ex_carry));
    chk({req, " R10 exact"}, longint'(res_exact), longint'(ex_exact));
    held = res_coef;
    @(negedge clk);
    chk({req, " R11 strobe drop"}, longint'(res_valid), 0);
    chk({req, " R11 hold"}, longint'(res_coef), longint'(held));
  endtask

  task automatic set_dq(input int a0, a1, a2, a3, a4, a5, a6, a7);
    dq[0] = a0; dq[1] = a1; dq[2] = a2; dq[3] = a3;
    dq[4] = a4; dq[5] = a5; dq[6] = a6; dq[7] = a7;
  endtask

  task automatic t_guard_low;   set_dq(1,2,3,4,5,6,7,3); run_case("R5 guard<5 R2", 0, 0); endtask
  task automatic t_guard_high;  set_dq(2,0,0,0,0,0,0,7); run_case("R5 guard>5", 0, 0); endtask
  task automatic t_tie_even;    set_dq(1,0,0,0,0,0,2,5); run_case("R6 tie even", 0, 1); endtask
  task automatic t_tie_odd;     set_dq(1,0,0,0,0,0,3,5); run_case("R6 tie odd", 0, 1); endtask
  task automatic t_tie_sticky;  set_dq(1,0,0,0,0,0,2,5); run_case("R7 tie sticky", 0, 0); endtask
  task automatic t_neg_rem;     set_dq(1,0,0,0,0,0,2,5); run_case("R4 negative rem", 1, 0); endtask
  task automatic t_mixed;       set_dq(3,-9,0,5,-3,9,0,-1); run_case("R2 mixed signs", 0, 0); endtask
  task automatic t_borrow;      set_dq(5,0,0,0,0,0,0,-3); run_case("R4 R2 borrow chain", 1, 0); endtask
  task automatic t_carry;       set_dq(9,9,9,9,9,9,9,6); run_case("R9 all nines", 0, 0); endtask
  task automatic t_exact;       set_dq(4,5,0,0,0,0,1,0); run_case("R10 exact", 0, 1); endtask
  task automatic t_neg_ignored; set_dq(4,5,0,0,0,0,1,0); run_case("R8 neg ignored", 1, 1); endtask

  task automatic t_restart;
    set_dq(8,8,8,0,0,0,0,0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    send_digits(3);
    set_dq(1,2,3,4,5,6,7,3);
    run_case("R3 restart", 0, 0);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0; dig_valid = 1'b0; dig = '0;
    fin_valid = 1'b0; rem_neg = 1'b0; rem_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", longint'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", longint'(res_valid), 0);
    chk("R1 coef", longint'(res_coef), 0);
    chk("R1 carry", longint'(res_carry), 0);
    chk("R1 exact", longint'(res_exact), 0);
    t_guard_low();
    t_guard_high();
    t_tie_even();
    t_tie_odd();
    t_tie_sticky();
    t_neg_rem();
    t_mixed();
    t_borrow();
    t_carry();
    t_exact();
    t_neg_ignored();
    t_restart();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule